// File: doc/BRIEF.md
# Externally Clocked Serial Result Port with Cascade Input

This block sends a converter's 16-bit result to a host over a serial line. The host supplies the bit clock. The block samples that clock, and a cascade data input, into its own system clock with two-flop synchronizers. It finds clock edges in the system clock domain, so the external clock may run at up to one quarter of the system clock rate.

When a new result arrives with its valid strobe, the word is loaded into a shift register. Its most significant bit appears on the serial output at once. Each active edge of the external clock moves the output to the next lower bit. An active edge counts only while chip select is low. The synchronized cascade input enters the shift register at the bottom. After the block's own bits, the serial output therefore carries the bits of an upstream device, which lets several units share one line.

A polarity input chooses which external clock edge updates the output. If a read has begun but is not finished when the next result arrives, the old word is lost. The new word takes its place, and a one-cycle error pulse is raised.

Top module: `slave_shift_port`

## Requirements
- R1: After reset the serial output is 0, the error output is 0 and the bit count is zero.
- R2: In the cycle after the result-valid strobe is high, the shift register holds the new word and the serial output equals its bit 15.
- R3: Each active external clock edge moves the serial output one bit lower, so the word goes out from bit 15 down to bit 0. The output changes within three system clock cycles of the external clock transition.
- R4: With the polarity input at 0 only rising external clock edges update the output; with it at 1 only falling edges do. The other edge leaves the output unchanged.
- R5: The cascade input level sampled at active edge j appears on the serial output after active edge j+15. The first cascade bit therefore follows bit 0 of the block's own word, 16 active edges after the read starts.
- R6: External clock edges that occur while chip select is high neither shift the register nor advance the bit count.
- R7: The output enable is 1 exactly when chip select and read are both low.
- R8: If a new result arrives after 1 to 15 active edges have been counted since the last load, the error output is 1 for exactly one system clock cycle. The new word is loaded in that same cycle.
- R9: A new result that arrives after zero active edges, or after 16 or more, raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resultData | input | 16 | Result word to be sent |
| resultValid | input | 1 | One-cycle strobe that loads resultData |
| sclkIn | input | 1 | External bit clock (asynchronous) |
| sdiIn | input | 1 | Cascade data input (asynchronous) |
| csN | input | 1 | Chip select, active low; gates the external clock |
| rdN | input | 1 | Read strobe, active low |
| sclkInvert | input | 1 | 0: rising edge updates output; 1: falling edge |
| sdOut | output | 1 | Serial data output |
| sdOutEn | output | 1 | Tri-state enable for sdOut |
| readError | output | 1 | One-cycle pulse when an unfinished read is overwritten |

## Verification
Random result words and random cascade patterns are read out with both clock polarities. This tells apart a correct bit order from a reversed one, and the right update edge from the wrong one, because the output is also checked during the idle half of each clock period. Directed sequences load a new word after 0, 5, 15 and 16 active edges, which separates reads that must raise an error from those that must not. Clock toggles sent while chip select is high show whether gating holds the bit position. Every chip-select and read combination is applied to the output enable.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } sspStrobes_t;
endpackage

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  output logic sclkLvl,
  output logic sclkPrev,
  output logic sdiBit
);
  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclkPipe[g] <= 1'b0;
            sdiPipe[g]  <= 1'b0;
          end else begin
            sclkPipe[g] <= sclkIn;
            sdiPipe[g]  <= sdiIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclkPipe[g] <= 1'b0;
            sdiPipe[g]  <= 1'b0;
          end else begin
            sclkPipe[g] <= sclkPipe[g-1];
            sdiPipe[g]  <= sdiPipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkPipe[SYNC_STAGES-1];
  end

  assign sclkLvl = sclkPipe[SYNC_STAGES-1];
  assign sdiBit  = sdiPipe[SYNC_STAGES-1];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkLvl,
  input  logic        sclkPrev,
  input  logic        sclkInvert,
  input  logic        csN,
  input  logic        resultValid,
  output sspStrobes_t strobes,
  output logic        readError
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

  logic [CNT_W-1:0] bitCount;
  logic riseEdge, fallEdge, activeEdge, incomplete;

  assign riseEdge   = sclkLvl & ~sclkPrev;
  assign fallEdge   = ~sclkLvl & sclkPrev;
  assign activeEdge = sclkInvert ? fallEdge : riseEdge;
  assign incomplete = (bitCount != '0) && (bitCount < FULL);

  always_comb begin
    strobes.load  = resultValid;
    strobes.shift = activeEdge & ~csN & ~resultValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount  <= '0;
      readError <= 1'b0;
    end else begin
      readError <= resultValid & incomplete;
      if (resultValid)
        bitCount <= '0;
      else if (strobes.shift && bitCount != FULL)
        bitCount <= bitCount + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= FULL);  // R3
  AST_GATED_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !resultValid) |=> $stable(bitCount));  // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    readError |=> !readError);  // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    readError |-> $past(resultValid));  // R8
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sspStrobes_t      strobes,
  input  logic [WIDTH-1:0] resultData,
  input  logic             sdiBit,
  output logic             sdOut
);
  logic [WIDTH-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strobes.load)
      shiftReg <= resultData;
    else if (strobes.shift)
      shiftReg <= {shiftReg[WIDTH-2:0], sdiBit};
  end

  assign sdOut = shiftReg[WIDTH-1];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.shift) |=> $stable(sdOut));  // R3
endmodule

// File: rtl/slave_shift_port.sv
module slave_shift_port
  import ssp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] resultData,
  input  logic             resultValid,
  input  logic             sclkIn,
  input  logic             sdiIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             sclkInvert,
  output logic             sdOut,
  output logic             sdOutEn,
  output logic             readError
);
  sspStrobes_t strobes;
  logic sclkLvl, sclkPrev, sdiBit;

  ssp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) syncI (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .sclkLvl(sclkLvl), .sclkPrev(sclkPrev), .sdiBit(sdiBit)
  );

  ssp_ctrl #(.WIDTH(WIDTH)) ctrlI (
    .clk(clk), .rstN(rstN), .sclkLvl(sclkLvl), .sclkPrev(sclkPrev),
    .sclkInvert(sclkInvert), .csN(csN), .resultValid(resultValid),
    .strobes(strobes), .readError(readError)
  );

  ssp_datapath #(.WIDTH(WIDTH)) dpI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .resultData(resultData),
    .sdiBit(sdiBit), .sdOut(sdOut)
  );

  assign sdOutEn = ~(csN | rdN);

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> sdOut == $past(resultData[WIDTH-1]));  // R2
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> !sdOutEn);  // R7
endmodule

// File: tb/slave_shift_port_tb.sv
module slave_shift_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] resultData = '0;
  logic resultValid = 1'b0;
  logic sclkIn = 1'b0;
  logic sdiIn = 1'b0;
  logic csN = 1'b1;
  logic rdN = 1'b1;
  logic sclkInvert = 1'b0;
  logic sdOut, sdOutEn, readError;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  slave_shift_port dut_i (
    .clk(clk), .rstN(rstN), .resultData(resultData), .resultValid(resultValid),
    .sclkIn(sclkIn), .sdiIn(sdiIn), .csN(csN), .rdN(rdN),
    .sclkInvert(sclkInvert), .sdOut(sdOut), .sdOutEn(sdOutEn),
    .readError(readError)
  );

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [15:0] w, input logic [31:0] ch, input int k);
    return (k < 16) ? w[15-k] : ch[k-16];
  endfunction

  function automatic logic idleLvl(input logic inv);
    return inv;
  endfunction

  task automatic setPolarity(input logic inv);
    @(negedge clk);
    csN = 1'b1;
    sclkInvert = inv;
    sclkIn = idleLvl(inv);
    repeat (6) @(negedge clk);
  endtask

  task automatic loadWord(input logic [15:0] w, input logic expErr, input string req);
    @(negedge clk);
    resultData = w;
    resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
    check(req, readError, expErr);
    check("R2", sdOut, w[15]);
    @(negedge clk);
    check("R8", readError, 1'b0);
  endtask

  // runs active edges firstK+1 .. firstK+n, checks output on both halves
  task automatic readEdges(input logic [15:0] w, input logic [31:0] ch,
                           input int firstK, input int n);
    csN = 1'b0;
    for (int k = firstK + 1; k <= firstK + n; k++) begin
      sdiIn = ch[k-1];
      repeat (4) @(negedge clk);
      sclkIn = ~idleLvl(sclkInvert);
      repeat (4) @(negedge clk);
      check((k > 16) ? "R5" : "R3", sdOut, expBit(w, ch, k));
      sclkIn = idleLvl(sclkInvert);
      repeat (4) @(negedge clk);
      check("R4", sdOut, expBit(w, ch, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [31:0] ch;
    void'($urandom(32'h5A5A_1234));
    repeat (3) @(negedge clk);
    check("R1", sdOut, 1'b0);
    check("R1", readError, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", sdOut, 1'b0);
    check("R1", readError, 1'b0);

    // R7 enable truth table
    for (int c = 0; c < 4; c++) begin
      csN = c[0];
      rdN = c[1];
      #1;
      check("R7", sdOutEn, (c == 0));
    end
    csN = 1'b1;
    rdN = 1'b0;

    // random words, both polarities, with cascade (R3 R4 R5)
    for (int i = 0; i < 8; i++) begin
      setPolarity(i[0]);
      w = 16'($urandom);
      ch = $urandom;
      loadWord(w, 1'b0, "R9");
      readEdges(w, ch, 0, 24);
    end

    // directed alternating patterns
    setPolarity(1'b0);
    loadWord(16'hAAAA, 1'b0, "R9");
    readEdges(16'hAAAA, 32'h0000_FFFF, 0, 20);
    setPolarity(1'b1);
    loadWord(16'h8001, 1'b0, "R9");
    readEdges(16'h8001, 32'h0000_00A5, 0, 24);

    // R6: clock toggles with CS high do not move the bit position
    setPolarity(1'b0);
    w = 16'h5C3A;
    loadWord(w, 1'b0, "R9");
    readEdges(w, 32'h0, 0, 3);
    csN = 1'b1;
    for (int t = 0; t < 3; t++) begin
      repeat (4) @(negedge clk);
      sclkIn = 1'b1;
      repeat (4) @(negedge clk);
      check("R6", sdOut, w[12]);
      sclkIn = 1'b0;
    end
    repeat (4) @(negedge clk);
    readEdges(w, 32'h0, 3, 13);

    // R8: overwrite mid-read
    w = 16'h1234;
    loadWord(w, 1'b0, "R9");
    readEdges(w, 32'h0, 0, 5);
    w = 16'hF0E1;
    loadWord(w, 1'b1, "R8");
    readEdges(w, 32'h0, 0, 15);
    loadWord(16'h0F0F, 1'b1, "R8");
    // R9: zero edges, then a full read
    loadWord(16'h7E81, 1'b0, "R9");
    readEdges(16'h7E81, 32'h3, 0, 16);
    loadWord(16'hC3C3, 1'b0, "R9");
    readEdges(16'hC3C3, 32'h0, 0, 2);
    setPolarity(1'b1);
    loadWord(16'h00FF, 1'b1, "R8");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule